// File: doc/BRIEF.md
# Ripple-Carry ALU with Set-Less-Than

This block is a purely combinational arithmetic logic unit assembled from a chain of identical single-bit cells. Each cell holds a full adder, an AND gate and an OR gate, and a four-way selector picks which of those (or an auxiliary "less" line) becomes that cell's result bit. The carry from each cell enters the next one up, so an addition settles only after the carry has rippled across the whole width.

An operand-B inversion control flips B before it reaches both the gates and the adder. Together with the carry-in of the lowest cell, this turns the adder into a subtractor (A plus the inverted B plus one). For the compare operation the unit subtracts. It then takes the sum bit of the top cell, which is the raw sign of the difference, and returns it on the "less" line of the lowest cell. Every other cell sees a constant zero on its "less" line. The comparison is not corrected for signed overflow.

The unit has no clock, no state and no handshake. A surrounding datapath holds the operands and the control lines steady and reads the result once the carry chain has settled.

Top module: `ripple_alu`

## Requirements
- R1: With op_sel = 0 and b_inv = 0, result equals the bitwise AND of a and b.
- R2: With op_sel = 1, result equals the bitwise OR of a and the effective B operand, which is b when b_inv = 0 and ~b when b_inv = 1.
- R3: With op_sel = 2, b_inv = 0 and carry_in = 0, {carry_out, result} equals the unsigned sum a + b.
- R4: With op_sel = 2, b_inv = 1 and carry_in = 1, result equals a - b modulo 2^WIDTH, and carry_out is 1 exactly when a >= b unsigned.
- R5: With op_sel = 3, b_inv = 1 and carry_in = 1, result bit 0 equals bit WIDTH-1 of a - b. There is no overflow correction, so the most negative value compared against 1 gives 0.
- R6: For every op_sel value, carry_out equals bit WIDTH of a + B_eff + carry_in, where B_eff is the effective B operand.
- R7: With op_sel = 2, b_inv = 0 and carry_in = 1, result equals a + b + 1 modulo 2^WIDTH.
- R8: With op_sel = 0 and b_inv = 1, result equals a AND NOT b.
- R9: With op_sel = 3, result bits WIDTH-1 down to 1 are always 0, whatever the operands and controls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand, optionally inverted |
| op_sel | input | 2 | Output select: 0 AND, 1 OR, 2 sum, 3 less |
| b_inv | input | 1 | Invert operand B before the gates and the adder |
| carry_in | input | 1 | Carry into the lowest cell |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Carry out of the highest cell, for every operation |

## Verification
The hardest case to reach from the ports is a compare where the subtraction overflows. There the sign bit that is fed back disagrees with the true signed order, and the unit must still return that raw, uncorrected bit. Random operands seldom straddle the most negative value in the right way. So a 4-bit copy of the unit is swept over every operand pair and every control combination, which covers every overflow pattern. The full-width unit then gets a cross product of edge operands (zero, one, all ones, largest positive and most negative) in addition to random vectors.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;
  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } alu_sel_e;
endpackage

// File: rtl/ripple_alu_fa.sv
module ripple_alu_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic half;
  assign half = x ^ y;
  assign s    = half ^ ci;
  assign co   = (x & y) | (half & ci);
endmodule

// File: rtl/ripple_alu_mux4.sv
module ripple_alu_mux4 (
  input  logic [1:0] sel,
  input  logic       in0,
  input  logic       in1,
  input  logic       in2,
  input  logic       in3,
  output logic       y
);
  import ripple_alu_pkg::*;
  always_comb begin
    unique case (alu_sel_e'(sel))
      SEL_AND:  y = in0;
      SEL_OR:   y = in1;
      SEL_SUM:  y = in2;
      default:  y = in3;
    endcase
  end
endmodule

// File: rtl/ripple_alu_slice.sv
module ripple_alu_slice (
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       b_inv,
  input  logic       ci,
  input  logic       less,
  input  logic [1:0] sel,
  output logic       res,
  output logic       sum,
  output logic       co
);
  logic b_eff;
  assign b_eff = b_bit ^ b_inv;

  ripple_alu_fa u_fa (
    .x  (a_bit),
    .y  (b_eff),
    .ci (ci),
    .s  (sum),
    .co (co)
  );

  ripple_alu_mux4 u_mux (
    .sel (sel),
    .in0 (a_bit & b_eff),
    .in1 (a_bit | b_eff),
    .in2 (sum),
    .in3 (less),
    .y   (res)
  );
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       op_sel,
  input  logic             b_inv,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] sums;
  logic             sign_fb;

  assign chain[0]  = carry_in;
  assign sign_fb   = sums[TOP];
  assign carry_out = chain[WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic less_in;
    if (i == 0) begin : g_low
      assign less_in = sign_fb;
    end else begin : g_rest
      assign less_in = 1'b0;
    end

    ripple_alu_slice u_cell (
      .a_bit (a[i]),
      .b_bit (b[i]),
      .b_inv (b_inv),
      .ci    (chain[i]),
      .less  (less_in),
      .sel   (op_sel),
      .res   (result[i]),
      .sum   (sums[i]),
      .co    (chain[i+1])
    );
  end
endmodule

// File: rtl/ripple_alu_chk.sv
module ripple_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [1:0]       op_sel,
  input logic             b_inv,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  localparam int EXT = WIDTH + 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  always_comb begin
    b_eff = b_inv ? ~b : b;
    full  = EXT'(a) + EXT'(b_eff) + EXT'(carry_in);

    if (op_sel == 2'd0)
      AST_AND_FORM: assert (result == (a & b_eff)); // R1
    if (op_sel == 2'd1)
      AST_OR_FORM: assert (result == (a | b_eff)); // R2
    if (op_sel == 2'd2)
      AST_SUM_FORM: assert (result == full[WIDTH-1:0]); // R3
    if (op_sel == 2'd3)
      AST_LESS_UPPER_ZERO: assert (result[WIDTH-1:1] == '0); // R9
    if (op_sel == 2'd3)
      AST_LESS_SIGN: assert (result[0] == full[WIDTH-1]); // R5
    AST_CARRY_OUT: assert (carry_out == full[WIDTH]); // R6
  end
endmodule

bind ripple_alu ripple_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a         (a),
  .b         (b),
  .op_sel    (op_sel),
  .b_inv     (b_inv),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/ripple_alu_test.sv
module ripple_alu_test;
  localparam int CLK_PERIOD = 10;
  localparam int SMALL_W    = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0]        a32, b32, res32;
  logic [SMALL_W-1:0] a4, b4, res4;
  logic [1:0]         sel;
  logic               binv, cin, co32, co4;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  ripple_alu #(.WIDTH(32)) uut (
    .a(a32), .b(b32), .op_sel(sel), .b_inv(binv), .carry_in(cin),
    .result(res32), .carry_out(co32)
  );

  ripple_alu #(.WIDTH(SMALL_W)) uut_small (
    .a(a4), .b(b4), .op_sel(sel), .b_inv(binv), .carry_in(cin),
    .result(res4), .carry_out(co4)
  );

  function automatic logic [32:0] model(input int w, input logic [31:0] av,
      input logic [31:0] bv, input logic [1:0] s, input logic bi, input logic ci);
    logic [63:0] mask, aa, bb, sm, rr;
    mask = (64'd1 << w) - 64'd1;
    aa   = {32'd0, av} & mask;
    bb   = (bi ? ~{32'd0, bv} : {32'd0, bv}) & mask;
    sm   = aa + bb + {63'd0, ci};
    case (s)
      2'd0:    rr = aa & bb;
      2'd1:    rr = aa | bb;
      2'd2:    rr = sm & mask;
      default: rr = (sm >> (w - 1)) & 64'd1;
    endcase
    return {sm[w], rr[31:0]};
  endfunction

  function automatic string tag_of(input logic [1:0] s, input logic bi, input logic ci);
    if (s == 2'd0) return bi ? "R8" : "R1";
    if (s == 2'd1) return "R2";
    if (s == 2'd3) return "R5/R9";
    if (bi && ci)  return "R4";
    if (!bi && ci) return "R7";
    return "R3";
  endfunction

  task automatic apply(input int w, input logic [31:0] av, input logic [31:0] bv,
      input logic [1:0] s, input logic bi, input logic ci);
    logic [32:0] exp_v;
    logic [31:0] got_r;
    logic        got_c;
    @(posedge clk);
    sel = s; binv = bi; cin = ci;
    if (w == SMALL_W) begin a4 = av[SMALL_W-1:0]; b4 = bv[SMALL_W-1:0]; end
    else begin a32 = av; b32 = bv; end
    @(negedge clk);
    exp_v = model(w, av, bv, s, bi, ci);
    if (w == SMALL_W) begin got_r = {28'd0, res4}; got_c = co4; end
    else begin got_r = res32; got_c = co32; end
    n_vec++;
    if (got_r !== exp_v[31:0]) begin
      n_bad++;
      $display("FAIL %s w=%0d sel=%0d binv=%0b cin=%0b a=%h b=%h result actual=%h expected=%h",
               tag_of(s, bi, ci), w, s, bi, ci, av, bv, got_r, exp_v[31:0]);
    end
    if (got_c !== exp_v[32]) begin
      n_bad++;
      $display("FAIL R6 w=%0d sel=%0d binv=%0b cin=%0b a=%h b=%h carry actual=%b expected=%b",
               w, s, bi, ci, av, bv, got_c, exp_v[32]);
    end
  endtask

  initial begin
    logic [31:0] edges [5];
    edges[0] = 32'h0000_0000; edges[1] = 32'h0000_0001; edges[2] = 32'hFFFF_FFFF;
    edges[3] = 32'h7FFF_FFFF; edges[4] = 32'h8000_0000;
    a32 = '0; b32 = '0; a4 = '0; b4 = '0; sel = 2'd0; binv = 1'b0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state with all-zero inputs: AND of zeros, no carry (R1, R6)
    apply(32, 32'd0, 32'd0, 2'd0, 1'b0, 1'b0);

    // Directed: uncorrected compare, most negative vs 1 gives 0 (R5)
    apply(32, 32'h8000_0000, 32'h0000_0001, 2'd3, 1'b1, 1'b1);
    // Directed: -1 < 0 signed raw sign is 1 (R5), upper bits zero (R9)
    apply(32, 32'hFFFF_FFFF, 32'h0000_0000, 2'd3, 1'b1, 1'b1);
    // Directed: all-ones plus one wraps with carry (R3, R6)
    apply(32, 32'hFFFF_FFFF, 32'h0000_0001, 2'd2, 1'b0, 1'b0);
    // Directed: equal operands subtract to zero, carry set (R4)
    apply(32, 32'h1234_5678, 32'h1234_5678, 2'd2, 1'b1, 1'b1);
    // Directed: increment through carry_in (R7), AND-NOT (R8)
    apply(32, 32'h0000_00FF, 32'h0000_0000, 2'd2, 1'b0, 1'b1);
    apply(32, 32'hF0F0_F0F0, 32'hFF00_FF00, 2'd0, 1'b1, 1'b0);

    // Exhaustive sweep of the narrow unit over all controls and operands
    for (int s = 0; s < 4; s++)
      for (int bi = 0; bi < 2; bi++)
        for (int ci = 0; ci < 2; ci++)
          for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
              apply(SMALL_W, 32'(x), 32'(y), 2'(s), 1'(bi), 1'(ci));

    // Edge operand cross product on the full-width unit
    for (int s = 0; s < 4; s++)
      for (int bi = 0; bi < 2; bi++)
        for (int ci = 0; ci < 2; ci++)
          for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
              apply(32, edges[i], edges[j], 2'(s), 1'(bi), 1'(ci));

    // Random operands with all control combinations
    for (int k = 0; k < 2000; k++)
      apply(32, $urandom, $urandom, 2'($urandom), 1'($urandom), 1'($urandom));

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired after %0d cycles, actual=hung expected=complete", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule